// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a write-through cache and main memory. Stores from the processor are captured in a small queue and accepted at once, so the processor does not wait for the memory write to complete. The queue presents its oldest entry on a ready/valid memory write port and retires one entry for each accepted handshake, always in arrival order.

Before a cache read miss is sent to memory, its address is looked up against every occupied slot of the queue. If a slot holds that address, the queued data is returned and the miss must not be served from memory, which would still hold the old value. If several slots hold the address, the youngest one supplies the data. A build option replaces forwarding with a simpler policy: a read is held back until the queue is empty. A second option lets a store to an address already queued overwrite that entry in place. This saves a slot and keeps the drain order unchanged.

Top module: `wbuf_fwd`

## Requirements
- R1: After reset the queue is empty: `mem_valid` is 0, `wr_ready` is 1 and a lookup reports no hit.
- R2: Accepted stores appear on the memory port in the order they were accepted, one per cycle with `mem_valid && mem_ready`. While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr` and `mem_data` hold steady. `mem_valid` is 0 once every entry has drained.
- R3: With `DEPTH` (default 4) entries occupied, a store whose address matches no mergeable entry sees `wr_ready` at 0 and is not taken. The occupancy never exceeds `DEPTH`.
- R4: A drain handshake on a full queue frees a slot, and `wr_ready` is 1 for a new address in the following cycle.
- R5: With forwarding selected (`FWD_MODE`=1), `rd_hit` is 1 and `rd_data` is the queued data when `rd_req` is 1 and `rd_addr` equals the address of an occupied entry. Otherwise `rd_hit` is 0. A store accepted in cycle t is visible to lookups from cycle t+1 onward, and not in cycle t itself.
- R6: When more than one occupied entry matches the lookup address, `rd_data` comes from the most recently accepted one.
- R7: With merging selected (`MERGE_EN`=1), a store to an address held by an occupied entry other than the one now at the head of the queue replaces that entry's data. No new slot is taken and the drain order is unchanged. A store matching only the head entry takes a new slot.
- R8: A store that merges is accepted (`wr_ready` 1) even when the queue is full.
- R9: With stalling selected (`FWD_MODE`=0), `rd_hit` stays 0 and `rd_stall` is 1 whenever `rd_req` is 1 while any entry is occupied. `rd_stall` is 0 once the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor store request |
| wr_ready | output | 1 | Store can be taken this cycle |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| rd_req | input | 1 | Read miss lookup request |
| rd_addr | input | AW | Read miss address |
| rd_hit | output | 1 | Queued data returned for the lookup |
| rd_data | output | DW | Forwarded data |
| rd_stall | output | 1 | Read must wait (stall mode only) |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_addr | output | AW | Address of the offered entry |
| mem_data | output | DW | Data of the offered entry |

## Verification
Some properties are checked by assertions on every cycle. The occupancy never exceeds the depth and never goes below zero. The valid flags agree with the occupancy counter. The offered memory word holds steady while memory is not ready. A merge leaves the occupancy unchanged. A hit is reported only with a non-empty queue. The bench scenarios are the only check of values: they show which data wins among several matching entries, the exact drain order after a merge and after a repeat store to the head address, and that a store is not visible to a lookup in its own cycle. They also show the stall-mode policy in a second instance.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
   import wbuf_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [AW-1:0]              push_addr,
   input  logic [DW-1:0]              push_data,
   input  logic                       upd,
   input  logic [PW-1:0]              upd_idx,
   input  logic [DW-1:0]              upd_data,
   input  logic                       pop,
   output logic [DEPTH-1:0]           vld,
   output logic [DEPTH-1:0][AW-1:0]   addrs,
   output logic [DEPTH-1:0][DW-1:0]   datas,
   output logic [PW-1:0]              head,
   output logic [CW-1:0]              count
);
   logic [PW-1:0] tail;

   initial begin
      assert (is_pow2(DEPTH)) else $error("DEPTH must be a power of two, at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld   <= '0;
         addrs <= '0;
         datas <= '0;
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (upd)
            datas[upd_idx] <= upd_data;
         if (pop) begin
            vld[head] <= 1'b0;
            head      <= head + PW'(1);
         end
         if (push) begin
            vld[tail]   <= 1'b1;
            addrs[tail] <= push_addr;
            datas[tail] <= push_data;
            tail        <= tail + PW'(1);
         end
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && !pop && count == CW'(DEPTH)));
   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && count == '0));
   assert_flags_match_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld) == int'(count));
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
   parameter int AW    = 8,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic [AW-1:0]             key,
   input  logic [DEPTH-1:0]          mask,
   input  logic [DEPTH-1:0][AW-1:0]  addrs,
   input  logic [PW-1:0]             oldest,
   output logic                      any,
   output logic [PW-1:0]             sel
);
   logic [DEPTH-1:0] hit;
   logic [PW-1:0]    idx;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = mask[g] && (addrs[g] == key);
   end

   // walk from oldest to youngest so the last match found is the newest
   always_comb begin
      sel = '0;
      idx = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = oldest + PW'(k);
         if (hit[idx])
            sel = idx;
      end
   end

   assign any = |hit;
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
   parameter int AW       = 8,
   parameter int DW       = 16,
   parameter int DEPTH    = 4,
   parameter bit FWD_MODE = 1'b1,
   parameter bit MERGE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   output logic          wr_ready,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_hit,
   output logic [DW-1:0] rd_data,
   output logic          rd_stall,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_data
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [DEPTH-1:0]          vld;
   logic [DEPTH-1:0][AW-1:0]  addrs;
   logic [DEPTH-1:0][DW-1:0]  datas;
   logic [PW-1:0]             head;
   logic [CW-1:0]             count;
   logic                      push, pop, merge_hit, can_merge, full;
   logic [DEPTH-1:0]          head_oh, merge_mask;
   logic                      w_any, r_any;
   logic [PW-1:0]             w_sel, r_sel;

   initial begin
      assert (AW > 0 && DW > 0) else $error("AW and DW must be positive");
   end

   assign head_oh    = DEPTH'(1) << head;
   assign merge_mask = vld & ~head_oh;   // head may be on the bus: never edit it
   assign full       = (count == CW'(DEPTH));
   assign mem_valid  = (count != '0);
   assign mem_addr   = addrs[head];
   assign mem_data   = datas[head];
   assign pop        = mem_valid && mem_ready;

   wbuf_match #(.AW(AW), .DEPTH(DEPTH)) u_wr_match (
      .key(wr_addr), .mask(merge_mask), .addrs(addrs), .oldest(head),
      .any(w_any), .sel(w_sel));

   if (MERGE_EN) begin : g_merge
      assign can_merge = w_any;
   end else begin : g_nomerge
      assign can_merge = 1'b0;
   end

   assign wr_ready  = can_merge || !full;
   assign merge_hit = wr_valid && can_merge;
   assign push      = wr_valid && wr_ready && !can_merge;

   wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_addr(wr_addr), .push_data(wr_data),
      .upd(merge_hit), .upd_idx(w_sel), .upd_data(wr_data),
      .pop(pop), .vld(vld), .addrs(addrs), .datas(datas),
      .head(head), .count(count));

   wbuf_match #(.AW(AW), .DEPTH(DEPTH)) u_rd_match (
      .key(rd_addr), .mask(vld), .addrs(addrs), .oldest(head),
      .any(r_any), .sel(r_sel));

   if (FWD_MODE) begin : g_fwd
      assign rd_hit   = rd_req && r_any;
      assign rd_data  = r_any ? datas[r_sel] : '0;
      assign rd_stall = 1'b0;
   end else begin : g_stall
      assign rd_hit   = 1'b0;
      assign rd_data  = '0;
      assign rd_stall = rd_req && mem_valid;
      assert_stall_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_req && count != '0) |-> rd_stall);
   end

   assert_mem_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
   assert_merge_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (merge_hit && !pop) |=> (count == $past(count)));
   assert_hit_needs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> (count != '0));
endmodule

// File: tb/wbuf_fwd_tb.sv
module wbuf_fwd_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int n_checks = 0;
   int n_err = 0;

   logic       wr_valid, wr_ready, rd_req, rd_hit, rd_stall, mem_valid, mem_ready;
   logic [7:0] wr_addr, rd_addr, mem_addr;
   logic [15:0] wr_data, rd_data, mem_data;

   logic       s_wv, s_wr, s_rq, s_hit, s_stall, s_mv, s_mr;
   logic [7:0] s_wa, s_ra, s_ma;
   logic [15:0] s_wd, s_rd, s_md;

   wbuf_fwd #(.AW(8), .DW(16), .DEPTH(4), .FWD_MODE(1'b1), .MERGE_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_hit(rd_hit), .rd_data(rd_data), .rd_stall(rd_stall),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data));

   wbuf_fwd #(.AW(8), .DW(16), .DEPTH(4), .FWD_MODE(1'b0), .MERGE_EN(1'b1)) dut_stall_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(s_wv), .wr_ready(s_wr),
      .wr_addr(s_wa), .wr_data(s_wd), .rd_req(s_rq), .rd_addr(s_ra),
      .rd_hit(s_hit), .rd_data(s_rd), .rd_stall(s_stall),
      .mem_valid(s_mv), .mem_ready(s_mr), .mem_addr(s_ma), .mem_data(s_md));

   typedef struct packed {
      logic        we;
      logic [7:0]  wa;
      logic [15:0] wd;
      logic        re;
      logic [7:0]  ra;
      logic        x_rdy;
      logic        x_hit;
      logic [15:0] x_data;
   } vec_t;

   // mem_ready held low throughout; each row is one cycle
   localparam vec_t TBL [7] = '{
      '{1'b1, 8'h10, 16'h1111, 1'b1, 8'h10, 1'b1, 1'b0, 16'h0000},  // R5 same-cycle store not visible
      '{1'b1, 8'h20, 16'h2222, 1'b1, 8'h10, 1'b1, 1'b1, 16'h1111},  // R5 forward
      '{1'b1, 8'h10, 16'h3333, 1'b1, 8'h20, 1'b1, 1'b1, 16'h2222},  // R7 head address: new slot
      '{1'b1, 8'h30, 16'h4444, 1'b1, 8'h10, 1'b1, 1'b1, 16'h3333},  // R6 newest of two matches
      '{1'b1, 8'h20, 16'h5555, 1'b1, 8'h30, 1'b1, 1'b1, 16'h4444},  // R8 merge while full
      '{1'b1, 8'h40, 16'h6666, 1'b1, 8'h20, 1'b0, 1'b1, 16'h5555},  // R3 full stall, R7 merged data
      '{1'b0, 8'h40, 16'h0000, 1'b1, 8'h50, 1'b0, 1'b0, 16'h0000}   // R5 miss, R3 still full
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step;
      @(negedge clk);
   endtask

   initial begin
      #200000;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      wr_valid = 0; wr_addr = 0; wr_data = 0; rd_req = 0; rd_addr = 0; mem_ready = 0;
      s_wv = 0; s_wa = 0; s_wd = 0; s_rq = 0; s_ra = 0; s_mr = 0;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      rd_req = 1; rd_addr = 8'h10;
      #1;
      chk("R1 mem_valid", mem_valid, 0);
      chk("R1 wr_ready", wr_ready, 1);
      chk("R1 rd_hit", rd_hit, 0);
      rd_req = 0;

      // table walk
      for (int i = 0; i < 7; i++) begin
         step();
         wr_valid = TBL[i].we; wr_addr = TBL[i].wa; wr_data = TBL[i].wd;
         rd_req = TBL[i].re; rd_addr = TBL[i].ra;
         #1;
         chk($sformatf("R3/R8 wr_ready row %0d", i), wr_ready, TBL[i].x_rdy);
         chk($sformatf("R5/R6 rd_hit row %0d", i), rd_hit, TBL[i].x_hit);
         if (TBL[i].x_hit)
            chk($sformatf("R5/R6 rd_data row %0d", i), rd_data, TBL[i].x_data);
      end
      step();
      wr_valid = 0; rd_req = 0;

      // R2 hold while not ready
      #1;
      chk("R2 mem_valid", mem_valid, 1);
      chk("R2 head addr", mem_addr, 8'h10);
      chk("R2 head data", mem_data, 16'h1111);
      step();
      #1;
      chk("R2 held addr", mem_addr, 8'h10);
      chk("R2 held data", mem_data, 16'h1111);
      mem_ready = 1;
      step();
      mem_ready = 0;
      wr_valid = 1; wr_addr = 8'h40; wr_data = 16'h6666;
      #1;
      chk("R4 slot freed", wr_ready, 1);
      step();
      wr_valid = 0;
      mem_ready = 1;
      #1;
      chk("R2 order addr 1", mem_addr, 8'h20);
      chk("R7 merged data drains", mem_data, 16'h5555);
      step(); #1;
      chk("R7 order addr 2", mem_addr, 8'h10);
      chk("R7 order data 2", mem_data, 16'h3333);
      step(); #1;
      chk("R2 order addr 3", mem_addr, 8'h30);
      chk("R2 order data 3", mem_data, 16'h4444);
      step(); #1;
      chk("R2 order addr 4", mem_addr, 8'h40);
      chk("R2 order data 4", mem_data, 16'h6666);
      step(); #1;
      chk("R2 drained", mem_valid, 0);
      mem_ready = 0;
      rd_req = 1; rd_addr = 8'h10;
      #1;
      chk("R5 no hit after drain", rd_hit, 0);
      rd_req = 0;

      // R9 stall-mode instance
      s_rq = 1; s_ra = 8'h10;
      #1;
      chk("R9 empty no stall", s_stall, 0);
      s_rq = 0;
      step();
      s_wv = 1; s_wa = 8'h10; s_wd = 16'hAAAA;
      step();
      s_wv = 0; s_rq = 1; s_ra = 8'h10;
      #1;
      chk("R9 stall while busy", s_stall, 1);
      chk("R9 no forward", s_hit, 0);
      s_rq = 1; s_ra = 8'h77;
      #1;
      chk("R9 stall any address", s_stall, 1);
      s_mr = 1;
      step();
      s_mr = 0;
      #1;
      chk("R9 released after drain", s_stall, 0);
      s_rq = 0;

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule